// File: doc/BRIEF.md
# Virtual Address Partition Decoder

This block sits between the address generation stage of a processor pipeline and its memory interface. Every virtual address is sorted into one of four fixed partitions by its three most significant bits. The partition decides whether the address is translated through the TLB or passed straight through as a physical address in the low 512 MB of memory. It also sets the default data cacheability and raises a fault when user-mode code touches an address reserved for the supervisor.

The TLB lookup is done elsewhere. This block takes the hit indication, the frame number and the cacheable flag of the matching entry, and combines them with the page offset. A parameter picks between a purely combinational decoder and one with a single register stage on all outputs.

Top module: `va_part_decoder`

## Requirements
- R1: The partition is chosen by vaddr_i[31:29]. 111 is the I/O partition and 110 is the kernel partition. 100 and 101 form the kernel-mapped partition, and 000 to 011 form the user partition. use_tlb_o is 0 for I/O and kernel, and 1 for kernel-mapped and user.
- R2: For I/O and kernel addresses, paddr_o equals vaddr_i with bits 31:29 forced to zero, whatever the TLB inputs are.
- R3: For kernel-mapped and user addresses with tlb_hit_i=1, paddr_o equals {tlb_pfn_i, vaddr_i[11:0]}.
- R4: For kernel-mapped and user addresses with tlb_hit_i=0, paddr_o is 0 and cacheable_o is 0.
- R5: For a normal data access, cacheable_o depends on the partition. It is 0 in the I/O partition and 1 in the kernel partition, and it equals tlb_c_i in the two translated partitions. Address bit 31 has no separate cache-bypass meaning.
- R6: When io_acc_i=1 (an I/O load or store), cacheable_o is 0 in every partition and for every tlb_c_i.
- R7: When fetch_i=1 (an instruction fetch), cacheable_o is 0, because cacheability describes data accesses only.
- R8: With user_i=1, an address in the I/O, kernel or kernel-mapped partition raises fault_fetch_o if fetch_i=1, and fault_data_o otherwise. At most one fault output is high. With user_i=0, or for a user-partition address, both fault outputs are 0. A fault does not change paddr_o, cacheable_o or use_tlb_o.
- R9: With REG_OUT=1, every output is all zeros while rst_ni is low. After reset, every output shows the combinational result one clock edge after its inputs. With REG_OUT=0, the outputs follow the inputs in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock for the optional output register |
| rst_ni | input | 1 | Active-low asynchronous reset |
| vaddr_i | input | 32 | Virtual address |
| user_i | input | 1 | 1 when the access comes from user mode |
| fetch_i | input | 1 | 1 for an instruction fetch, 0 for a data access |
| io_acc_i | input | 1 | 1 for an I/O load or store |
| tlb_hit_i | input | 1 | A TLB entry matched this address |
| tlb_pfn_i | input | 20 | Physical frame number of the matching entry |
| tlb_c_i | input | 1 | Cacheable flag of the matching entry |
| paddr_o | output | 32 | Physical address |
| cacheable_o | output | 1 | Access may use the data cache |
| use_tlb_o | output | 1 | Address goes through translation |
| fault_fetch_o | output | 1 | User-mode fetch from a supervisor-only address |
| fault_data_o | output | 1 | User-mode data access to a supervisor-only address |

## Verification
The assertions check the address rules on every cycle. On the bypass path they check that the top bits are cleared and the rest is passed through. On a hit they check the frame and offset concatenation, and on a miss that the address is zero. They also check that I/O accesses and fetches are never cacheable, that at most one fault output is high, that supervisor accesses never fault, and, in the registered variant, the one-cycle delay. The bench scenarios alone show the partition boundaries and the value of each partition's default cacheability. They also show which fault output a user access to each supervisor partition raises, and the reset value of the registered outputs.

// File: rtl/va_part_pkg.sv
package va_part_pkg;

  typedef enum logic [1:0] {
    PART_USER = 2'd0,
    PART_KMAP = 2'd1,
    PART_KERN = 2'd2,
    PART_IO   = 2'd3
  } part_e;

  localparam int unsigned SEG_W = 3;

endpackage

// File: rtl/va_part_classify.sv
module va_part_classify
  import va_part_pkg::*;
(
  input  logic [SEG_W-1:0] seg_i,
  output part_e            part_o,
  output logic             use_tlb_o
);

  always_comb begin
    unique casez (seg_i)
      3'b111:  part_o = PART_IO;
      3'b110:  part_o = PART_KERN;
      3'b10?:  part_o = PART_KMAP;
      default: part_o = PART_USER;
    endcase
  end

  assign use_tlb_o = (part_o == PART_KMAP) || (part_o == PART_USER);

endmodule

// File: rtl/va_part_addr.sv
module va_part_addr #(
  parameter int unsigned VA_W  = 32,
  parameter int unsigned PFN_W = 20,
  parameter int unsigned CLR_W = 3,
  localparam int unsigned OFF_W = VA_W - PFN_W,
  localparam int unsigned LOW_W = VA_W - CLR_W
) (
  input  logic [LOW_W-1:0] vlow_i,
  input  logic             use_tlb_i,
  input  logic             tlb_hit_i,
  input  logic [PFN_W-1:0] tlb_pfn_i,
  output logic [VA_W-1:0]  paddr_o
);

  logic [VA_W-1:0] byp_addr;
  logic [VA_W-1:0] map_addr;

  assign byp_addr = {{CLR_W{1'b0}}, vlow_i};
  assign map_addr = tlb_hit_i ? {tlb_pfn_i, vlow_i[OFF_W-1:0]} : '0;
  assign paddr_o  = use_tlb_i ? map_addr : byp_addr;

endmodule

// File: rtl/va_part_attr.sv
module va_part_attr
  import va_part_pkg::*;
(
  input  part_e part_i,
  input  logic  user_i,
  input  logic  fetch_i,
  input  logic  io_acc_i,
  input  logic  tlb_hit_i,
  input  logic  tlb_c_i,
  output logic  cacheable_o,
  output logic  fault_fetch_o,
  output logic  fault_data_o
);

  logic dflt_c;
  logic sup_only;

  always_comb begin
    unique case (part_i)
      PART_IO:   dflt_c = 1'b0;
      PART_KERN: dflt_c = 1'b1;
      default:   dflt_c = tlb_hit_i & tlb_c_i;
    endcase
  end

  assign sup_only      = (part_i != PART_USER);
  assign cacheable_o   = dflt_c & ~fetch_i & ~io_acc_i;
  assign fault_fetch_o = user_i & sup_only & fetch_i;
  assign fault_data_o  = user_i & sup_only & ~fetch_i;

endmodule

// File: rtl/va_part_decoder.sv
module va_part_decoder
  import va_part_pkg::*;
#(
  parameter int unsigned VA_W    = 32,
  parameter int unsigned PFN_W   = 20,
  parameter bit          REG_OUT = 1'b0
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [VA_W-1:0]  vaddr_i,
  input  logic             user_i,
  input  logic             fetch_i,
  input  logic             io_acc_i,
  input  logic             tlb_hit_i,
  input  logic [PFN_W-1:0] tlb_pfn_i,
  input  logic             tlb_c_i,
  output logic [VA_W-1:0]  paddr_o,
  output logic             cacheable_o,
  output logic             use_tlb_o,
  output logic             fault_fetch_o,
  output logic             fault_data_o
);

  localparam int unsigned LOW_W = VA_W - SEG_W;
  localparam int unsigned OFF_W = VA_W - PFN_W;
  localparam int unsigned OUT_W = VA_W + 4;

  part_e           part;
  logic            use_tlb_n;
  logic [VA_W-1:0] paddr_n;
  logic            cach_n;
  logic            ff_n;
  logic            fd_n;
  logic [OUT_W-1:0] out_n;
  logic [OUT_W-1:0] out_q;

  va_part_classify u_classify (
    .seg_i     (vaddr_i[VA_W-1 -: SEG_W]),
    .part_o    (part),
    .use_tlb_o (use_tlb_n)
  );

  va_part_addr #(
    .VA_W  (VA_W),
    .PFN_W (PFN_W),
    .CLR_W (SEG_W)
  ) u_addr (
    .vlow_i    (vaddr_i[LOW_W-1:0]),
    .use_tlb_i (use_tlb_n),
    .tlb_hit_i (tlb_hit_i),
    .tlb_pfn_i (tlb_pfn_i),
    .paddr_o   (paddr_n)
  );

  va_part_attr u_attr (
    .part_i        (part),
    .user_i        (user_i),
    .fetch_i       (fetch_i),
    .io_acc_i      (io_acc_i),
    .tlb_hit_i     (tlb_hit_i),
    .tlb_c_i       (tlb_c_i),
    .cacheable_o   (cach_n),
    .fault_fetch_o (ff_n),
    .fault_data_o  (fd_n)
  );

  assign out_n = {paddr_n, cach_n, use_tlb_n, ff_n, fd_n};

  generate
    if (REG_OUT) begin : g_reg
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) out_q <= '0;
        else         out_q <= out_n;
      end

      p_reg_delay_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $past(rst_ni) |-> (out_q == $past(out_n)));
    end else begin : g_comb
      assign out_q = out_n;
    end
  endgenerate

  assign {paddr_o, cacheable_o, use_tlb_o, fault_fetch_o, fault_data_o} = out_q;

  p_bypass_addr_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !use_tlb_n |-> (paddr_n[VA_W-1 -: SEG_W] == '0 && paddr_n[LOW_W-1:0] == vaddr_i[LOW_W-1:0]));

  p_map_addr_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (use_tlb_n && tlb_hit_i) |-> (paddr_n == {tlb_pfn_i, vaddr_i[OFF_W-1:0]}));

  p_miss_zero_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (use_tlb_n && !tlb_hit_i) |-> (paddr_n == '0 && !cach_n));

  p_io_uncached_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    io_acc_i |-> !cach_n);

  p_fetch_uncached_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fetch_i |-> !cach_n);

  p_fault_excl_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({ff_n, fd_n}));

  p_sup_nofault_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !user_i |-> !(ff_n || fd_n));

endmodule

// File: tb/va_part_decoder_bench.sv
`timescale 1ns/1ps
module va_part_decoder_bench;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] vaddr = '0;
  logic        user = 1'b0, fetch = 1'b0, io_acc = 1'b0, hit = 1'b0, tc = 1'b0;
  logic [19:0] pfn = '0;

  logic [31:0] pa_c, pa_r;
  logic        c_c, c_r, u_c, u_r, ff_c, ff_r, fd_c, fd_r;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #10 clk = ~clk;

  va_part_decoder u_va_part_decoder (
    .clk_i(clk), .rst_ni(rst_n), .vaddr_i(vaddr), .user_i(user), .fetch_i(fetch),
    .io_acc_i(io_acc), .tlb_hit_i(hit), .tlb_pfn_i(pfn), .tlb_c_i(tc),
    .paddr_o(pa_c), .cacheable_o(c_c), .use_tlb_o(u_c),
    .fault_fetch_o(ff_c), .fault_data_o(fd_c));

  va_part_decoder #(.REG_OUT(1'b1)) u_va_part_decoder_reg (
    .clk_i(clk), .rst_ni(rst_n), .vaddr_i(vaddr), .user_i(user), .fetch_i(fetch),
    .io_acc_i(io_acc), .tlb_hit_i(hit), .tlb_pfn_i(pfn), .tlb_c_i(tc),
    .paddr_o(pa_r), .cacheable_o(c_r), .use_tlb_o(u_r),
    .fault_fetch_o(ff_r), .fault_data_o(fd_r));

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // Drive on the falling edge, check the combinational copy, then the registered copy after the next rising edge.
  task automatic apply(input string tag, input logic [31:0] va, input logic us, input logic fe,
                       input logic io, input logic h, input logic [19:0] pf, input logic c,
                       input logic [31:0] e_pa, input logic e_c, input logic e_u,
                       input logic e_ff, input logic e_fd);
    @(negedge clk);
    vaddr = va; user = us; fetch = fe; io_acc = io; hit = h; pfn = pf; tc = c;
    #2;
    chk({tag, " paddr"}, pa_c, e_pa);
    chk({tag, " cacheable"}, {31'd0, c_c}, {31'd0, e_c});
    chk({tag, " use_tlb"}, {31'd0, u_c}, {31'd0, e_u});
    chk({tag, " faults"}, {30'd0, ff_c, fd_c}, {30'd0, e_ff, e_fd});
    @(posedge clk);
    #2;
    chk({tag, " R9 reg"}, {pa_r[31:4], c_r, u_r, ff_r, fd_r} ^ {28'd0, 4'd0},
        {e_pa[31:4], e_c, e_u, e_ff, e_fd});
    chk({tag, " R9 reg low"}, {28'd0, pa_r[3:0]}, {28'd0, e_pa[3:0]});
  endtask

  task automatic t_reset_r9;
    #3;
    chk("R9 reset paddr", pa_r, 32'd0);
    chk("R9 reset flags", {28'd0, c_r, u_r, ff_r, fd_r}, 32'd0);
  endtask

  task automatic t_partitions_r1;
    apply("R1 io top",    32'hFFFF_F000, 0,0,0, 1,20'h12345,1, 32'h1FFF_F000, 0,0, 0,0);
    apply("R1 io base",   32'hE000_0000, 0,0,0, 1,20'h12345,1, 32'h0000_0000, 0,0, 0,0);
    apply("R1 kern base", 32'hC000_1234, 0,0,0, 0,20'h0,0,     32'h0000_1234, 1,0, 0,0);
    apply("R1 kmap low",  32'h8000_0010, 0,0,0, 1,20'h00042,1, 32'h0004_2010, 1,1, 0,0);
    apply("R1 kmap high", 32'hBFFF_FFFF, 0,0,0, 1,20'h00042,0, 32'h0004_2FFF, 0,1, 0,0);
    apply("R1 user top",  32'h7FFF_FFFF, 0,0,0, 1,20'h00001,1, 32'h0000_1FFF, 1,1, 0,0);
  endtask

  task automatic t_bypass_r2;
    apply("R2 io",   32'hE123_4567, 0,0,0, 1,20'hFFFFF,1, 32'h0123_4567, 0,0, 0,0);
    apply("R2 kern", 32'hDFFF_FFFC, 0,0,0, 1,20'hFFFFF,0, 32'h1FFF_FFFC, 1,0, 0,0);
  endtask

  task automatic t_mapped_r3;
    apply("R3 user", 32'h0000_3ABC, 1,0,0, 1,20'hABCDE,0, 32'hABCD_EABC, 0,1, 0,0);
    apply("R3 kmap", 32'h9234_5FED, 0,0,0, 1,20'h00777,1, 32'h0077_7FED, 1,1, 0,0);
  endtask

  task automatic t_miss_r4;
    apply("R4 user miss", 32'h1234_5678, 0,0,0, 0,20'hABCDE,1, 32'h0, 0,1, 0,0);
    apply("R4 kmap miss", 32'hA000_0100, 0,0,0, 0,20'h11111,1, 32'h0, 0,1, 0,0);
  endtask

  task automatic t_cache_r5;
    apply("R5 kern ignores tlb_c", 32'hC800_0000, 0,0,0, 1,20'h0,0, 32'h0800_0000, 1,0, 0,0);
    apply("R5 io ignores tlb_c",   32'hF000_0000, 0,0,0, 1,20'h0,1, 32'h1000_0000, 0,0, 0,0);
    apply("R5 user c0",            32'h0000_0004, 0,0,0, 1,20'h00003,0, 32'h0000_3004, 0,1, 0,0);
  endtask

  task automatic t_ioacc_r6;
    apply("R6 kern io",  32'hC000_0040, 0,0,1, 0,20'h0,0, 32'h0000_0040, 0,0, 0,0);
    apply("R6 user io",  32'h0000_1040, 0,0,1, 1,20'h00009,1, 32'h0000_9040, 0,1, 0,0);
    apply("R6 kmap io",  32'h8000_1040, 0,0,1, 1,20'h00009,1, 32'h0000_9040, 0,1, 0,0);
  endtask

  task automatic t_fetch_r7;
    apply("R7 kern fetch", 32'hC000_0100, 0,1,0, 0,20'h0,0, 32'h0000_0100, 0,0, 0,0);
    apply("R7 user fetch", 32'h0000_5100, 1,1,0, 1,20'h00005,1, 32'h0000_5100, 0,1, 0,0);
  endtask

  task automatic t_fault_r8;
    apply("R8 user io data",    32'hE000_0008, 1,0,0, 0,20'h0,0, 32'h0000_0008, 0,0, 0,1);
    apply("R8 user kern fetch", 32'hC000_0008, 1,1,0, 0,20'h0,0, 32'h0000_0008, 0,0, 1,0);
    apply("R8 user kern data",  32'hD000_0008, 1,0,0, 0,20'h0,0, 32'h1000_0008, 1,0, 0,1);
    apply("R8 user kmap fetch", 32'h8000_0008, 1,1,0, 1,20'h00002,1, 32'h0000_2008, 0,1, 1,0);
    apply("R8 user kmap data",  32'hB000_0008, 1,0,0, 1,20'h00002,1, 32'h0000_2008, 1,1, 0,1);
    apply("R8 sup kmap fetch",  32'h8000_0008, 0,1,0, 1,20'h00002,1, 32'h0000_2008, 0,1, 0,0);
    apply("R8 user user data",  32'h7000_0008, 1,0,0, 1,20'h00002,1, 32'h0000_2008, 1,1, 0,0);
  endtask

  initial begin
    t_reset_r9;
    @(negedge clk);
    t_reset_r9;
    rst_n = 1'b1;
    t_partitions_r1;
    t_bypass_r2;
    t_mapped_r3;
    t_miss_r4;
    t_cache_r5;
    t_ioacc_r6;
    t_fetch_r7;
    t_fault_r8;
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (5000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule